// File: doc/BRIEF.md
# Saturating Word Multiply-Accumulate Unit

This block multiplies two signed 16-bit samples into a 32-bit product and adds that product into a pair of 32-bit accumulator registers. The pair is a high word and a low word. A mode input picks how overflow is handled, and the mode can change on every operation.

In saturating mode only the low word takes part in the sum. If the 32-bit signed sum overflows, the low word is clamped to the signed extreme on the side of the product's sign. Bit 0 of the high word is then set and stays set. In wrapping mode the pair behaves as one 64-bit accumulator: the high word takes the product's sign extension plus the carry out of the low-word addition.

Software-side logic can zero both words with a synchronous clear. It can also preload either word through its own load port, for example to start a new dot product or to restore saved context. One accumulate is performed per cycle in which the operand strobe is high.

Top module: `sat_mac16`

## Requirements
- R1: While `rst_n` is low, both `accHi` and `accLo` are zero.
- R2: An accumulate takes the 32-bit signed product of the signed 16-bit operands `opA` and `opB` and adds it to `accLo`. When the signed 32-bit sum does not overflow, `accLo` receives that sum in either mode.
- R3: In saturating mode (`satMode`=1), signed overflow is detected when the product and the old `accLo` have the same sign bit and the sum's sign bit differs. On overflow `accLo` becomes 32'h7FFFFFFF if the product is non-negative, and 32'h80000000 if it is negative.
- R4: In saturating mode an overflow sets bit 0 of `accHi`. That bit is never cleared by a later accumulate. Bits 31..1 of `accHi` are never changed by a saturating accumulate.
- R5: In wrapping mode (`satMode`=0), `accLo` receives the 32-bit sum modulo 2^32. `accHi` receives the old `accHi` plus 32'hFFFFFFFF when the product is negative, plus 1 when the unsigned sum is below the unsigned product. This equals adding the sign-extended product to the 64-bit value {accHi,accLo}.
- R6: `accClear` zeroes both words at the next rising edge and overrides the load ports and the operand strobe.
- R7: `loadHi` writes `loadHiData` into `accHi` and `loadLo` writes `loadLoData` into `accLo`, each independently. In a cycle where either load is high, the operand strobe is ignored.
- R8: In a cycle with none of `opValid`, `accClear`, `loadHi` and `loadLo` high, both words hold their values.
- R9: Every update shows on `accHi`/`accLo` right after the rising edge that samples the request, so back-to-back accumulates each use the previous cycle's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Perform one accumulate this cycle |
| opA | input | 16 | Signed multiplicand |
| opB | input | 16 | Signed multiplier |
| satMode | input | 1 | 1 = saturating on low word, 0 = 64-bit wrapping |
| accClear | input | 1 | Synchronous clear of both words |
| loadHi | input | 1 | Write `loadHiData` into the high word |
| loadHiData | input | 32 | Preload value for the high word |
| loadLo | input | 1 | Write `loadLoData` into the low word |
| loadLoData | input | 32 | Preload value for the low word |
| accHi | output | 32 | High accumulator word (bit 0 is the sticky overflow marker in saturating mode) |
| accLo | output | 32 | Low accumulator word |

## Verification
Each request is registered once, so every result is due on the outputs one rising edge after the cycle that presents it. The bench drives inputs 2 ns after a rising edge and samples 2 ns after the next one. Its reference model steps at that same edge, so back-to-back accumulates are compared cycle by cycle with no slack. The directed cases preload the low word next to each signed extreme to force overflow in both directions. They then check that the sticky bit survives later non-overflowing accumulates and that a wrapping carry reaches the high word.

// File: rtl/sat_mac16_pkg.sv
package sat_mac16_pkg;

  // Strobes handed from control to datapath, already prioritised
  typedef struct packed {
    logic clr;   // zero both words
    logic ldHi;  // preload high word
    logic ldLo;  // preload low word
    logic acc;   // perform one multiply-accumulate
    logic sat;   // overflow policy for this accumulate
  } macStrobe_t;

endpackage

// File: rtl/sat_mac16_ctrl.sv
module sat_mac16_ctrl
  import sat_mac16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opValid,
  input  logic       satMode,
  input  logic       accClear,
  input  logic       loadHi,
  input  logic       loadLo,
  output macStrobe_t strb
);

  logic anyLoad;

  always_comb begin
    anyLoad   = loadHi | loadLo;
    strb.clr  = accClear;
    strb.ldHi = loadHi & ~accClear;
    strb.ldLo = loadLo & ~accClear;
    strb.acc  = opValid & ~accClear & ~anyLoad;
    strb.sat  = satMode;
  end

  // R7
  load_blocks_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loadHi || loadLo) |-> !strb.acc);

  // R6
  clear_overrides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accClear |-> (!strb.acc && !strb.ldHi && !strb.ldLo));

endmodule

// File: rtl/sat_mac16_dp.sv
module sat_mac16_dp
  import sat_mac16_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  macStrobe_t        strb,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [2*OP_W-1:0] loadHiData,
  input  logic [2*OP_W-1:0] loadLoData,
  output logic [2*OP_W-1:0] accHi,
  output logic [2*OP_W-1:0] accLo
);

  localparam int ACC_W = 2 * OP_W;
  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

  logic signed [ACC_W-1:0] product;
  logic [ACC_W:0]          wideSum;
  logic [ACC_W-1:0]        rawSum;
  logic                    lowCarry;
  logic                    prodNeg;
  logic                    ovf;
  logic [ACC_W-1:0]        satLo, satHi;
  logic [ACC_W-1:0]        wrapHi;
  logic [ACC_W-1:0]        nextHi, nextLo;

  // Arithmetic core
  always_comb begin
    product  = $signed(opA) * $signed(opB);
    prodNeg  = product[ACC_W-1];
    wideSum  = {1'b0, accLo} + {1'b0, product};
    rawSum   = wideSum[ACC_W-1:0];
    lowCarry = wideSum[ACC_W];
    ovf      = (prodNeg == accLo[ACC_W-1]) && (rawSum[ACC_W-1] != prodNeg);

    // saturating policy: low word clamps, high word only gains the sticky bit
    satLo = ovf ? (prodNeg ? MAX_NEG : MAX_POS) : rawSum;
    satHi = ovf ? (accHi | ONE) : accHi;

    // wrapping policy: sign extension of product plus low carry
    wrapHi = accHi + {ACC_W{prodNeg}} + {{(ACC_W-1){1'b0}}, lowCarry};
  end

  // Next-state selection in priority order
  always_comb begin
    nextHi = accHi;
    nextLo = accLo;
    if (strb.clr) begin
      nextHi = '0;
      nextLo = '0;
    end else if (strb.ldHi || strb.ldLo) begin
      if (strb.ldHi) nextHi = loadHiData;
      if (strb.ldLo) nextLo = loadLoData;
    end else if (strb.acc) begin
      nextLo = strb.sat ? satLo : rawSum;
      nextHi = strb.sat ? satHi : wrapHi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accHi <= '0;
      accLo <= '0;
    end else begin
      accHi <= nextHi;
      accLo <= nextLo;
    end
  end

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.acc && strb.sat && !strb.clr && !strb.ldHi && accHi[0]) |=> accHi[0]);

  // R4
  sat_hi_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.acc && strb.sat && !strb.clr && !strb.ldHi && !strb.ldLo)
      |=> (accHi[ACC_W-1:1] == $past(accHi[ACC_W-1:1])));

  // R3
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.acc && strb.sat && !strb.clr && !strb.ldLo && !prodNeg && !accLo[ACC_W-1])
      |=> !accLo[ACC_W-1]);

  // R3
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.acc && strb.sat && !strb.clr && !strb.ldLo && prodNeg && accLo[ACC_W-1])
      |=> accLo[ACC_W-1]);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clr |=> (accHi == '0 && accLo == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clr && !strb.ldHi && !strb.ldLo && !strb.acc)
      |=> ($stable(accHi) && $stable(accLo)));

endmodule

// File: rtl/sat_mac16.sv
module sat_mac16
  import sat_mac16_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic              satMode,
  input  logic              accClear,
  input  logic              loadHi,
  input  logic [2*OP_W-1:0] loadHiData,
  input  logic              loadLo,
  input  logic [2*OP_W-1:0] loadLoData,
  output logic [2*OP_W-1:0] accHi,
  output logic [2*OP_W-1:0] accLo
);

  macStrobe_t strb;

  sat_mac16_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .satMode  (satMode),
    .accClear (accClear),
    .loadHi   (loadHi),
    .loadLo   (loadLo),
    .strb     (strb)
  );

  sat_mac16_dp #(.OP_W(OP_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .opA        (opA),
    .opB        (opB),
    .loadHiData (loadHiData),
    .loadLoData (loadLoData),
    .accHi      (accHi),
    .accLo      (accLo)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (accHi == '0 && accLo == '0));

endmodule

// File: tb/tb_sat_mac16.sv
module tb_sat_mac16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        satMode = 1'b0;
  logic        accClear = 1'b0;
  logic        loadHi = 1'b0;
  logic [31:0] loadHiData = '0;
  logic        loadLo = 1'b0;
  logic [31:0] loadLoData = '0;
  logic [31:0] accHi, accLo;

  int checks = 0;
  int fails  = 0;
  logic [31:0] refHi = '0;
  logic [31:0] refLo = '0;

  always #4 clk = ~clk;  // 125 MHz

  sat_mac16 dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opA(opA), .opB(opB),
    .satMode(satMode), .accClear(accClear), .loadHi(loadHi),
    .loadHiData(loadHiData), .loadLo(loadLo), .loadLoData(loadLoData),
    .accHi(accHi), .accLo(accLo)
  );

  // Reference: 64-bit arithmetic, independent of the design's formulation
  function automatic logic [63:0] macRef(input logic [31:0] hi, input logic [31:0] lo,
                                         input logic [15:0] a, input logic [15:0] b,
                                         input logic s);
    longint p, t;
    logic [63:0] w;
    p = longint'($signed(a)) * longint'($signed(b));
    if (s) begin
      t = p + longint'($signed(lo));
      if (t > 64'sd2147483647)       return {hi | 32'd1, 32'h7FFFFFFF};
      else if (t < -64'sd2147483648) return {hi | 32'd1, 32'h80000000};
      else                           return {hi, t[31:0]};
    end
    w = {hi, lo} + 64'(p);
    return w;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (accHi !== refHi || accLo !== refLo) begin
      fails++;
      $display("FAIL %s: got hi=%h lo=%h expected hi=%h lo=%h", tag, accHi, accLo, refHi, refLo);
    end
  endtask

  // Present one cycle of stimulus, step the model, sample after the edge
  task automatic cyc(input logic v, input logic [15:0] a, input logic [15:0] b,
                     input logic s, input logic clr, input logic lh, input logic [31:0] hd,
                     input logic ll, input logic [31:0] ld, input string tag);
    logic [63:0] r;
    opValid = v; opA = a; opB = b; satMode = s; accClear = clr;
    loadHi = lh; loadHiData = hd; loadLo = ll; loadLoData = ld;
    if (clr) begin
      refHi = '0; refLo = '0;
    end else if (lh || ll) begin
      if (lh) refHi = hd;
      if (ll) refLo = ld;
    end else if (v) begin
      r = macRef(refHi, refLo, a, b, s);
      refHi = r[63:32]; refLo = r[31:0];
    end
    @(posedge clk); #2;
    check(tag);
  endtask

  task automatic acc(input logic [15:0] a, input logic [15:0] b, input logic s, input string tag);
    cyc(1'b1, a, b, s, 1'b0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic ld(input logic lh, input logic [31:0] hd, input logic ll, input logic [31:0] lv,
                    input string tag);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, lh, hd, ll, lv, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset");
    rst_n = 1'b1;

    // R2 plain products, both modes
    acc(16'd300, 16'd7, 1'b1, "R2 sat small");
    acc(16'hFFFE, 16'd5, 1'b0, "R2 wrap negative product");
    acc(16'h8000, 16'h8000, 1'b1, "R2 max product");
    // R9 back to back
    acc(16'd3, 16'd3, 1'b1, "R9 back-to-back 1");
    acc(16'd4, 16'd4, 1'b1, "R9 back-to-back 2");

    // R3 positive overflow and R4 sticky set
    ld(1'b1, 32'h12345670, 1'b1, 32'h7FFF0000, "R7 load both");
    acc(16'h7FFF, 16'h7FFF, 1'b1, "R3 clamp positive");
    acc(16'd1, 16'hFFFF, 1'b1, "R4 sticky kept after no overflow");
    // R3 negative overflow
    ld(1'b0, '0, 1'b1, 32'h80000010, "R7 load lo only");
    acc(16'h8000, 16'h7FFF, 1'b1, "R3 clamp negative");
    acc(16'h8000, 16'h7FFF, 1'b1, "R3 stay at negative extreme");

    // R5 wrap carry into hi and borrow
    ld(1'b1, 32'd5, 1'b1, 32'hFFFFFFF0, "R7 preload for carry");
    acc(16'd16, 16'd2, 1'b0, "R5 carry into hi");
    acc(16'hFFFF, 16'd64, 1'b0, "R5 borrow from hi");
    // wrap mode past the positive limit: no clamp, no sticky
    ld(1'b1, 32'd0, 1'b1, 32'h7FFFFFFF, "R7 preload near limit");
    acc(16'd1, 16'd1, 1'b0, "R5 no clamp in wrap mode");

    // R7 load blocks operand strobe
    cyc(1'b1, 16'h7FFF, 16'h7FFF, 1'b1, 1'b0, 1'b1, 32'hA5A5A5A5, 1'b0, '0, "R7 load hi blocks acc");
    // R6 clear overrides loads and accumulate
    cyc(1'b1, 16'd9, 16'd9, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, "R6 clear priority");
    // R8 idle hold
    acc(16'd50, 16'd50, 1'b0, "R2 after clear");
    cyc(1'b0, 16'h7FFF, 16'h7FFF, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R8 idle hold");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int sel;
      sel = $urandom_range(0, 19);
      if (sel == 0)
        cyc(1'b1, 16'($urandom), 16'($urandom), 1'($urandom), 1'b1, 1'b0, '0, 1'b0, '0, "R6 random clear");
      else if (sel < 3)
        ld(1'($urandom), $urandom, 1'b1,
           (sel == 1) ? (32'h7FFFFFFF - 32'($urandom_range(0, 65535) << 12))
                      : (32'h80000000 + 32'($urandom_range(0, 65535) << 12)),
           "R7 random preload");
      else if (sel == 3)
        cyc(1'b0, 16'($urandom), 16'($urandom), 1'($urandom), 1'b0, 1'b0, '0, 1'b0, '0, "R8 random idle");
      else
        acc(16'($urandom), 16'($urandom), 1'($urandom), "R3 R5 random accumulate");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule